// File: doc/BRIEF.md
# Variable-Length Immediate Field Extractor

This block sits beside an instruction fetch unit and collects an immediate operand that follows an opcode in the byte stream. A one-cycle start strobe carries a 2-bit size code and an extend flag. The block then accepts one byte per valid/ready handshake until it holds the number of bytes the code asks for. It widens the value to 32 bits, either by zero fill or by sign extension from the most significant byte it received, and presents the value with a single-cycle done pulse.

Along with the value it reports how many bytes it took, so the fetch logic can move its byte pointer past the operand without decoding the size code a second time. Bytes are little-endian: the earliest byte forms the least significant part of the value.

Top module: `imm_extract`

## Requirements
- R1: The size code selects the byte count. Code 1 takes one byte, code 2 takes two, code 3 takes three and code 0 takes four. `consumed_o` shows that count (1 to 4) from the done cycle until the next completion.
- R2: Bytes are placed least significant first. The k-th byte taken (k counted from 0) lands in `result_o[8k+7:8k]`.
- R3: With `sext_i` set at start, a 1-, 2- or 3-byte value is sign-extended from bit 7, 15 or 23 respectively.
- R4: With `sext_i` clear at start, every result bit above the bytes received is zero.
- R5: For code 0 (four bytes) the result is the four bytes unchanged, whatever the value of `sext_i`.
- R6: A byte is taken only in a cycle where `byte_valid_i` and `byte_ready_o` are both high. `byte_ready_o` is low while idle and falls in the cycle after the last required byte is taken.
- R7: The size code and extend flag are captured from a start accepted while idle, and this includes the cycle in which done is high. A start that arrives while bytes are still being collected is ignored and changes neither the count nor the result.
- R8: `done_o` is high for exactly one cycle, the cycle after the final byte is taken. `result_o` and `consumed_o` change only in that cycle and hold their values otherwise.
- R9: After synchronous reset, `byte_ready_o` and `done_o` are low and `result_o` and `consumed_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for a new operand |
| size_code_i | input | 2 | Byte count code (0 means four bytes) |
| sext_i | input | 1 | Sign-extend request |
| byte_i | input | 8 | Incoming stream byte |
| byte_valid_i | input | 1 | Stream byte is valid |
| byte_ready_o | output | 1 | Block will take a byte this cycle |
| result_o | output | 32 | Assembled and widened operand |
| done_o | output | 1 | Single-cycle completion pulse |
| consumed_o | output | 3 | Bytes taken by the last operand |

## Verification
The assertions assume that reset is held for at least two cycles, so that history-based checks start from defined register values. They also assume that `byte_i` carries meaningful data only while `byte_valid_i` is high. The stimulus holds reset for several cycles and drives every input at the falling clock edge. It inserts idle gaps between bytes and keeps `byte_valid_i` asserted past the end of an operand, which tests that bytes are refused while `byte_ready_o` is low. It also pulses start in the middle of an operand and again in the done cycle, so it covers both the ignored start and the accepted start without leaving legal handshake behaviour.

// File: rtl/imm_pkg.sv
package imm_pkg;

    localparam int LANE_W    = 8;
    localparam int MAX_LANES = 4;
    localparam int WORD_W    = LANE_W * MAX_LANES;
    localparam int CODE_W    = 2;
    localparam int CNT_W     = $clog2(MAX_LANES + 1);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } fill_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] need;
        logic             sext;
    } fill_req_t;

    // Code 0 selects the full width; any other code is the count itself.
    function automatic logic [CNT_W-1:0] lanes_for_code(input logic [CODE_W-1:0] code);
        if (code == '0) begin
            return CNT_W'(MAX_LANES);
        end
        return CNT_W'(code);
    endfunction

endpackage

// File: rtl/imm_size_decode.sv
module imm_size_decode
    import imm_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  count_o
);

    always_comb begin
        count_o = lanes_for_code(code_i);
    end

endmodule

// File: rtl/imm_byte_collector.sv
module imm_byte_collector #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int IDX_W  = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear_i,
    input  logic                    take_i,
    input  logic [LANE_W-1:0]       byte_i,
    output logic [LANES*LANE_W-1:0] word_o,
    output logic [IDX_W-1:0]        idx_o
);

    logic [LANE_W-1:0] lane_q    [LANES];
    logic [LANE_W-1:0] lane_next [LANES];
    logic [IDX_W-1:0]  idx_q;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_comb begin
            lane_next[k] = (take_i && idx_q == IDX_W'(k)) ? byte_i : lane_q[k];
        end

        always_ff @(posedge clk) begin
            if (rst || clear_i) begin
                lane_q[k] <= '0;
            end else begin
                lane_q[k] <= lane_next[k];
            end
        end

        assign word_o[k*LANE_W +: LANE_W] = lane_next[k];
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            idx_q <= '0;
        end else if (take_i) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign idx_o = idx_q;

    // R2: the write position never runs past the last lane
    a_r2_idx_bound: assert property (@(posedge clk) disable iff (rst)
        idx_q <= IDX_W'(LANES));

endmodule

// File: rtl/imm_sign_fill.sv
module imm_sign_fill #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int CNT_W  = $clog2(LANES + 1)
) (
    input  logic [LANES*LANE_W-1:0] word_i,
    input  logic [CNT_W-1:0]        count_i,
    input  logic                    sext_i,
    output logic [LANES*LANE_W-1:0] word_o
);

    logic sign_bit;
    logic fill_bit;

    always_comb begin
        sign_bit = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            if (count_i == CNT_W'(k + 1)) begin
                sign_bit = word_i[(k+1)*LANE_W-1];
            end
        end
        fill_bit = sext_i & sign_bit;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_fill
        assign word_o[k*LANE_W +: LANE_W] = (CNT_W'(k) < count_i)
                                          ? word_i[k*LANE_W +: LANE_W]
                                          : {LANE_W{fill_bit}};
    end

endmodule

// File: rtl/imm_extract.sv
module imm_extract
    import imm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CODE_W-1:0] size_code_i,
    input  logic              sext_i,
    input  logic [LANE_W-1:0] byte_i,
    input  logic              byte_valid_i,
    output logic              byte_ready_o,
    output logic [WORD_W-1:0] result_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  consumed_o
);

    fill_state_e       state_q;
    fill_req_t         req_q;
    logic [CNT_W-1:0]  code_count;
    logic [CNT_W-1:0]  idx;
    logic [WORD_W-1:0] raw_word;
    logic [WORD_W-1:0] filled_word;
    logic              start_ok;
    logic              take;
    logic              last_take;
    logic [WORD_W-1:0] result_q;
    logic [CNT_W-1:0]  count_q;
    logic              done_q;

    imm_size_decode u_decode (
        .code_i  (size_code_i),
        .count_o (code_count)
    );

    assign start_ok  = start_i && (state_q == ST_IDLE);
    assign take      = (state_q == ST_FILL) && byte_valid_i;
    assign last_take = take && ((idx + 1'b1) == req_q.need);

    imm_byte_collector #(
        .LANES  (MAX_LANES),
        .LANE_W (LANE_W),
        .IDX_W  (CNT_W)
    ) u_collect (
        .clk     (clk),
        .rst     (rst),
        .clear_i (start_ok),
        .take_i  (take),
        .byte_i  (byte_i),
        .word_o  (raw_word),
        .idx_o   (idx)
    );

    imm_sign_fill #(
        .LANES  (MAX_LANES),
        .LANE_W (LANE_W),
        .CNT_W  (CNT_W)
    ) u_fill (
        .word_i  (raw_word),
        .count_i (req_q.need),
        .sext_i  (req_q.sext),
        .word_o  (filled_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
        end else if (start_ok) begin
            state_q     <= ST_FILL;
            req_q.need  <= code_count;
            req_q.sext  <= sext_i;
        end else if (last_take) begin
            state_q <= ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            count_q  <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= last_take;
            if (last_take) begin
                result_q <= filled_word;
                count_q  <= req_q.need;
            end
        end
    end

    assign byte_ready_o = (state_q == ST_FILL);
    assign result_o     = result_q;
    assign consumed_o   = count_q;
    assign done_o       = done_q;

    // R8: completion is a lone pulse
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: completion follows a handshake in the previous cycle
    a_r8_done_after_take: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(byte_ready_o && byte_valid_i));

    // R8: outputs only move in the done cycle
    a_r8_result_held: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(result_o) && $stable(consumed_o)));

    // R6: no more bytes wanted once complete
    a_r6_ready_low_on_done: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !byte_ready_o);

    // R1: reported count stays within one to four
    a_r1_count_range: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (consumed_o >= CNT_W'(1) && consumed_o <= CNT_W'(MAX_LANES)));

endmodule

// File: tb/imm_extract_tb_top.sv
`timescale 1ns/1ps
module imm_extract_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  size_code_i = 2'd0;
    logic        sext_i = 1'b0;
    logic [7:0]  byte_i = 8'd0;
    logic        byte_valid_i = 1'b0;
    logic        byte_ready_o;
    logic [31:0] result_o;
    logic        done_o;
    logic [2:0]  consumed_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    imm_extract dut_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .size_code_i  (size_code_i),
        .sext_i       (sext_i),
        .byte_i       (byte_i),
        .byte_valid_i (byte_valid_i),
        .byte_ready_o (byte_ready_o),
        .result_o     (result_o),
        .done_o       (done_o),
        .consumed_o   (consumed_o)
    );

    // ---------------- behavioural reference ----------------
    bit          m_busy, m_done, m_sx;
    int          m_need, m_got, m_cnt;
    logic [31:0] m_acc, m_res;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_need = 0; m_got = 0;
            m_acc = 0; m_res = 0; m_cnt = 0; m_sx = 0;
        end else begin
            m_done = 0;
            if (!m_busy) begin
                if (start_i) begin
                    m_busy = 1; m_got = 0; m_acc = 0; m_sx = sext_i;
                    m_need = (size_code_i == 0) ? 4 : int'(size_code_i);
                end
            end else if (byte_valid_i) begin
                m_acc = m_acc | (32'(byte_i) << (8 * m_got));
                m_got++;
                if (m_got == m_need) begin
                    m_busy = 0; m_done = 1; m_cnt = m_need;
                    m_res = m_acc;
                    if (m_need < 4 && m_sx && m_acc[8*m_need-1])
                        m_res = m_acc | (32'hFFFF_FFFF << (8 * m_need));
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            n_cmp++;
            if (byte_ready_o !== m_busy) begin
                n_bad++;
                $display("FAIL R6 ready act=%0b exp=%0b", byte_ready_o, m_busy);
            end
            n_cmp++;
            if (done_o !== m_done) begin
                n_bad++;
                $display("FAIL R8 done act=%0b exp=%0b", done_o, m_done);
            end
            n_cmp++;
            if (result_o !== m_res || consumed_o !== 3'(m_cnt)) begin
                n_bad++;
                $display("FAIL R8 hold act=%h/%0d exp=%h/%0d", result_o, consumed_o, m_res, m_cnt);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Start at the current falling edge, then feed bytes with the given gap;
    // intrude pulses a foreign start after the first byte. Returns at the done edge.
    task automatic run_job(input logic [1:0] code, input bit sx, input logic [7:0] b [4],
                           input int gap, input bit intrude, input bit trail);
        int n;
        int i;
        n = (code == 0) ? 4 : int'(code);
        start_i = 1; size_code_i = code; sext_i = sx;
        @(negedge clk);
        start_i = 0; size_code_i = 2'd1; sext_i = ~sx;
        i = 0;
        while (i < n) begin
            for (int g = 0; g < gap; g++) begin
                byte_valid_i = 0;
                @(negedge clk);
            end
            begin
                bit r;
                r = byte_ready_o;
                byte_valid_i = 1; byte_i = b[i];
                start_i = (intrude && i == 1);
                @(posedge clk);
                if (r) i++;
                @(negedge clk);
                start_i = 0;
            end
        end
        byte_valid_i = trail;
        byte_i = 8'hEE;
        for (int w = 0; w < 8 && !done_o; w++) @(negedge clk);
    endtask

    function automatic logic [31:0] expect_val(input int n, input bit sx, input logic [7:0] b [4]);
        logic [31:0] v;
        case (n)
            1: v = sx ? {{24{b[0][7]}}, b[0]} : {24'd0, b[0]};
            2: v = sx ? {{16{b[1][7]}}, b[1], b[0]} : {16'd0, b[1], b[0]};
            3: v = sx ? {{8{b[2][7]}}, b[2], b[1], b[0]} : {8'd0, b[2], b[1], b[0]};
            default: v = {b[3], b[2], b[1], b[0]};
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] bs [4];
        repeat (5) @(negedge clk);
        rst = 0;
        // R9 reset state
        check("R9 ready", 32'(byte_ready_o), 0);
        check("R9 done", 32'(done_o), 0);
        check("R9 result", result_o, 0);
        check("R9 consumed", 32'(consumed_o), 0);
        // R6 idle ignores bytes
        byte_valid_i = 1; byte_i = 8'h55;
        repeat (3) @(negedge clk);
        check("R6 idle no take", result_o, 0);
        byte_valid_i = 0;

        bs = '{8'h85, 8'h00, 8'h00, 8'h00};
        run_job(2'd1, 0, bs, 0, 0, 0);
        check("R4 one byte zero fill", result_o, expect_val(1, 0, bs));
        check("R1 code1 count", 32'(consumed_o), 1);
        run_job(2'd1, 1, bs, 1, 0, 0);
        check("R3 one byte sext", result_o, 32'hFFFF_FF85);
        bs = '{8'h7F, 8'h00, 8'h00, 8'h00};
        run_job(2'd1, 1, bs, 0, 0, 0);
        check("R3 one byte positive", result_o, 32'h0000_007F);

        bs = '{8'h34, 8'h92, 8'h00, 8'h00};
        run_job(2'd2, 1, bs, 2, 0, 0);
        check("R3 two byte sext", result_o, 32'hFFFF_9234);
        check("R1 code2 count", 32'(consumed_o), 2);
        run_job(2'd2, 0, bs, 0, 0, 0);
        check("R2 two byte order", result_o, expect_val(2, 0, bs));

        bs = '{8'h01, 8'h02, 8'h83, 8'h00};
        run_job(2'd3, 1, bs, 1, 0, 0);
        check("R3 three byte sext", result_o, 32'hFF83_0201);
        check("R1 code3 count", 32'(consumed_o), 3);
        run_job(2'd3, 0, bs, 0, 0, 1);
        check("R4 three byte zero fill", result_o, 32'h0083_0201);
        byte_valid_i = 0;

        bs = '{8'h11, 8'h22, 8'h33, 8'hC4};
        run_job(2'd0, 0, bs, 0, 0, 0);
        check("R2 four byte order", result_o, 32'hC433_2211);
        check("R1 code0 count", 32'(consumed_o), 4);
        run_job(2'd0, 1, bs, 1, 0, 0);
        check("R5 four byte sext no effect", result_o, 32'hC433_2211);

        // R7 start while collecting is ignored
        bs = '{8'hA0, 8'hB1, 8'hC2, 8'h00};
        run_job(2'd3, 1, bs, 0, 1, 0);
        check("R7 intruding start count", 32'(consumed_o), 3);
        check("R7 intruding start value", result_o, 32'hFFC2_B1A0);

        // R6 valid held after completion, next operand unaffected
        bs = '{8'h80, 8'h01, 8'h00, 8'h00};
        run_job(2'd2, 0, bs, 0, 0, 1);
        repeat (3) @(negedge clk);
        check("R6 surplus bytes refused", result_o, 32'h0000_0180);
        byte_valid_i = 0;
        bs = '{8'hFF, 8'h00, 8'h00, 8'h00};
        run_job(2'd1, 1, bs, 0, 0, 0);
        check("R6 next operand clean", result_o, 32'hFFFF_FFFF);
        repeat (4) @(negedge clk);
        check("R8 held after done", result_o, 32'hFFFF_FFFF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule